// File: doc/BRIEF.md
# Erase Region Walker

This block turns an erase request, given as a start address and a byte length, into a series of sector-erase addresses. It sends these addresses one at a time to a flash command sequencer. The flash has several regions, and each region has its own sector size. Software loads a small table of packed region descriptors through a write port. The block places the regions back to back from offset zero of each chip, in index order, and checks that together they fill one chip exactly.

When a request arrives, the block first checks it. The request must lie inside the device, which is a set of identical chips. Each chip is 2^CHIP_SHIFT bytes. Both ends of the request must be aligned to the sector size of the region they fall in. If the request passes, the block walks the range in ascending order. It offers each address under a valid/ready handshake and waits for the sequencer to report that the erase finished before offering the next one. The step size follows the region the current address lies in. When the address passes a chip boundary, the walk continues at offset zero of the next chip.

Every request ends with a single `done` pulse that carries a two-bit outcome code. An erase failure reported by the sequencer ends the walk at once.

Top module: `erase_walker`

## Requirements
- R1: Decoding of region descriptor i (bits [31:16] = hi, bits [15:0] = lo):
  - The sector size is hi × 256 bytes and the sector count is lo + 1.
  - Only entries 0 to `rgn_count`-1 take part.
  - Each entry starts where the previous one ends, beginning at offset 0 of a chip.
- R2: If the used entries do not add up to exactly 2^CHIP_SHIFT bytes, the request ends with `done_code` 3 and no address is issued.
- R3: A request whose start is greater than the device size (NUM_CHIPS × 2^CHIP_SHIFT), or whose start + length is greater than it, ends with `done_code` 1 and issues no address.
- R4: The start must be a multiple of the sector size of the last region whose offset is not above the start's in-chip offset. Otherwise the request ends with `done_code` 1.
- R5: The end (start + length) is located the same way and must be aligned the same way, or the request ends with `done_code` 1. An end equal to the device size is accepted.
- R6: Issued addresses start at the request start and ascend. Each step equals the sector size of the region that holds the current address, so the step changes when a region boundary is crossed.
- R7: When the in-chip offset reaches 2^CHIP_SHIFT, the next address is the base of the next chip, which lies in that chip's region 0.
- R8: Only one address is outstanding at a time:
  - `ers_addr` holds steady while `ers_valid` waits for `ers_ready`.
  - After a handshake, nothing new is offered until `cmpl_valid` arrives.
- R9: A completion with `cmpl_fail` high ends the walk at once with `done_code` 2 and issues no further address. This takes priority over success, even on the last sector.
- R10: `done` is a one-cycle pulse. `done_code` 0 is reported only after the issued sectors cover the full length. A zero-length request that passes the checks reports 0 without issuing any address.
- R11: After reset, `req_ready` is 1, and both `ers_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rgn_we | input | 1 | Region table write strobe |
| rgn_idx | input | $clog2(MAX_REG) | Table entry to write |
| rgn_desc | input | 32 | Packed region descriptor |
| rgn_count | input | $clog2(MAX_REG+1) | Number of table entries in use |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted |
| req_start | input | ADDR_W | Request start address |
| req_len | input | ADDR_W | Request length in bytes |
| ers_valid | output | 1 | Sector address offered |
| ers_ready | input | 1 | Sequencer takes the address |
| ers_addr | output | ADDR_W | Sector address to erase |
| cmpl_valid | input | 1 | Erase of the taken sector finished |
| cmpl_fail | input | 1 | That erase failed |
| done | output | 1 | Request finished (one-cycle pulse) |
| done_code | output | 2 | 0 ok, 1 bad request, 2 erase failed, 3 bad table |

## Verification
The completion of the last sector can also be the cycle in which the remaining length reaches zero. In that cycle, a failure flag and the success ending compete. The bench makes the completion of the final sector of a walk a failure and expects `done_code` 2, never 0.

A region change and a chip wrap can also fall on the same step. A request that starts in the last region of chip 0 must continue with the small sectors at the base of chip 1, and the scoreboard checks each address against a walk computed independently from the bench's own copy of the table.

// File: rtl/erase_walker.sv
module erase_walker #(
  parameter int CHIP_SHIFT = 16,
  parameter int NUM_CHIPS  = 2,
  parameter int ADDR_W     = 18,
  parameter int MAX_REG    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rgn_we,
  input  logic [$clog2(MAX_REG)-1:0]     rgn_idx,
  input  logic [31:0]                    rgn_desc,
  input  logic [$clog2(MAX_REG+1)-1:0]   rgn_count,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [ADDR_W-1:0]              req_start,
  input  logic [ADDR_W-1:0]              req_len,
  output logic                           ers_valid,
  input  logic                           ers_ready,
  output logic [ADDR_W-1:0]              ers_addr,
  input  logic                           cmpl_valid,
  input  logic                           cmpl_fail,
  output logic                           done,
  output logic [1:0]                     done_code
);

  localparam int SW = 48;
  localparam logic [ADDR_W:0] TOTAL   = (ADDR_W+1)'(NUM_CHIPS) << CHIP_SHIFT;
  localparam logic [SW-1:0]   CHIP_SZ = SW'(1) << CHIP_SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [31:0]       desc [MAX_REG];
  logic [SW-1:0]     rsz  [MAX_REG];
  logic [SW-1:0]     roff [MAX_REG];
  logic [SW-1:0]     tile_sum, cur_sz, beg_sz, end_sz;
  logic [SW-1:0]     cur_loc, beg_loc, end_loc;
  logic [ADDR_W-1:0] addr, rem, start_q, len_q, step;
  logic [ADDR_W:0]   end_a;
  logic              cfg_bad, range_bad, align_bad;

  always_comb begin
    logic [SW-1:0] acc;
    acc = '0;
    for (int i = 0; i < MAX_REG; i++) begin
      rsz[i]  = SW'({desc[i][31:16], 8'h00});
      roff[i] = acc;
      if (i < int'(rgn_count))
        acc = acc + rsz[i] * (SW'(desc[i][15:0]) + SW'(1));
    end
    tile_sum = acc;
  end

  assign end_a   = {1'b0, start_q} + {1'b0, len_q};
  assign cur_loc = SW'(addr[CHIP_SHIFT-1:0]);
  assign beg_loc = SW'(start_q[CHIP_SHIFT-1:0]);
  assign end_loc = SW'(end_a[CHIP_SHIFT-1:0]);

  always_comb begin
    cur_sz = rsz[0];
    beg_sz = rsz[0];
    end_sz = rsz[0];
    for (int i = 0; i < MAX_REG; i++) begin
      if (i < int'(rgn_count)) begin
        if (roff[i] <= cur_loc) cur_sz = rsz[i];
        if (roff[i] <= beg_loc) beg_sz = rsz[i];
        if (roff[i] <= end_loc) end_sz = rsz[i];
      end
    end
  end

  assign step      = ADDR_W'(cur_sz);
  assign cfg_bad   = (tile_sum != CHIP_SZ);
  assign range_bad = ({1'b0, start_q} > TOTAL) || (end_a > TOTAL);
  assign align_bad = (|(beg_loc & (beg_sz - SW'(1)))) || (|(end_loc & (end_sz - SW'(1))));

  assign req_ready = (st == S_IDLE);
  assign ers_valid = (st == S_ISSUE);
  assign ers_addr  = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      done_code <= 2'd0;
      addr      <= '0;
      rem       <= '0;
      start_q   <= '0;
      len_q     <= '0;
      for (int i = 0; i < MAX_REG; i++) desc[i] <= '0;
    end else begin
      done <= 1'b0;
      if (rgn_we) desc[rgn_idx] <= rgn_desc;
      case (st)
        S_IDLE: if (req_valid) begin
          start_q <= req_start;
          len_q   <= req_len;
          st      <= S_CHECK;
        end
        S_CHECK: begin
          addr <= start_q;
          rem  <= len_q;
          if (cfg_bad) begin
            done <= 1'b1; done_code <= 2'd3; st <= S_IDLE;
          end else if (range_bad || align_bad) begin
            done <= 1'b1; done_code <= 2'd1; st <= S_IDLE;
          end else if (len_q == '0) begin
            done <= 1'b1; done_code <= 2'd0; st <= S_IDLE;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: if (ers_ready) st <= S_WAIT;
        S_WAIT: if (cmpl_valid) begin
          if (cmpl_fail) begin
            done <= 1'b1; done_code <= 2'd2; st <= S_IDLE;
          end else begin
            addr <= addr + step;
            rem  <= rem - step;
            if (rem <= step) begin
              done <= 1'b1; done_code <= 2'd0; st <= S_IDLE;
            end else begin
              st <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_valid && !ers_ready) |=> (ers_valid && $stable(ers_addr)));

  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_valid && ers_ready) |=> !ers_valid);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_no_issue_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && cmpl_valid && cmpl_fail) |=> (done && done_code == 2'd2 && !ers_valid));

  a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ers_valid |-> ({1'b0, ers_addr} < TOTAL));

  a_r2_check_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!done && !ers_valid));

endmodule

// File: tb/erase_walker_tb.sv
module erase_walker_tb;
  localparam int AW = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rgn_we = 1'b0;
  logic [1:0] rgn_idx = '0;
  logic [31:0] rgn_desc = '0;
  logic [2:0] rgn_count = '0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_start = '0, req_len = '0;
  logic ers_valid, ers_ready = 1'b0;
  logic [AW-1:0] ers_addr;
  logic cmpl_valid = 1'b0, cmpl_fail = 1'b0;
  logic done;
  logic [1:0] done_code;

  erase_walker u_dut (
    .clk(clk), .rst_n(rst_n), .rgn_we(rgn_we), .rgn_idx(rgn_idx), .rgn_desc(rgn_desc),
    .rgn_count(rgn_count), .req_valid(req_valid), .req_ready(req_ready), .req_start(req_start),
    .req_len(req_len), .ers_valid(ers_valid), .ers_ready(ers_ready), .ers_addr(ers_addr),
    .cmpl_valid(cmpl_valid), .cmpl_fail(cmpl_fail), .done(done), .done_code(done_code));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int done_seen = 0;
  int cyc = 0;
  int pend = 0;
  logic pf = 1'b0;
  logic [AW-1:0] fail_at = '1;
  string cur_tag = "";
  logic [AW-1:0] exp_addr[$];
  int exp_code[$];
  logic [31:0] bdesc [4];
  int bcnt = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint bsize(input longint a);
    longint loc, off, sz, res;
    loc = a & 64'hFFFF;
    off = 0;
    res = 0;
    for (int i = 0; i < bcnt; i++) begin
      sz = longint'(bdesc[i][31:16]) * 256;
      if (off <= loc) res = sz;
      off = off + sz * (longint'(bdesc[i][15:0]) + 1);
    end
    return res;
  endfunction

  always @(negedge clk) begin
    logic newr;
    cyc++;
    cmpl_valid = 1'b0;
    cmpl_fail  = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        cmpl_valid = 1'b1;
        cmpl_fail  = pf;
      end
    end
    newr = (cyc % 3) != 0;
    ers_ready = newr;
    if (rst_n && ers_valid && newr) begin
      if (exp_addr.size() == 0) begin
        chk(1'b0, {cur_tag, " R8 unexpected address"}, ers_addr, 0);
      end else begin
        logic [AW-1:0] e;
        e = exp_addr.pop_front();
        chk(ers_addr == e, {cur_tag, " R6 address"}, ers_addr, e);
      end
      pf = (ers_addr == fail_at);
      pend = 2;
    end
    if (rst_n && done) begin
      int ec;
      ec = (exp_code.size() != 0) ? exp_code.pop_front() : -1;
      chk(int'(done_code) == ec, {cur_tag, " R10 done_code"}, done_code, ec);
      done_seen++;
    end
  end

  task automatic load(input int n, input logic [31:0] d0, input logic [31:0] d1);
    bdesc[0] = d0; bdesc[1] = d1; bcnt = n;
    @(negedge clk);
    rgn_we = 1'b1; rgn_idx = 2'd0; rgn_desc = d0;
    @(negedge clk);
    rgn_idx = 2'd1; rgn_desc = d1;
    @(negedge clk);
    rgn_we = 1'b0; rgn_count = 3'(n);
  endtask

  task automatic run(input logic [AW-1:0] s, input logic [AW-1:0] l,
                     input logic [AW-1:0] fa, input int code, input string tag);
    longint a, r, sz;
    int target;
    cur_tag = tag;
    if (code == 0 || code == 2) begin
      a = s; r = l;
      while (r > 0) begin
        exp_addr.push_back(AW'(a));
        if (AW'(a) == fa) break;
        sz = bsize(a);
        a = a + sz;
        r = r - sz;
      end
    end
    exp_code.push_back(code);
    fail_at = fa;
    target = done_seen + 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_start = s; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
    while (done_seen < target) @(negedge clk);
    chk(exp_addr.size() == 0, {tag, " R8 leftover addresses"}, exp_addr.size(), 0);
    exp_addr.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 req_ready", req_ready, 1);
    chk(ers_valid == 1'b0, "R11 ers_valid", ers_valid, 0);
    chk(done == 1'b0,      "R11 done", done, 0);

    load(2, 32'h0010_0003, 32'h0040_0001);
    run(18'h00000, 18'h04000, '1, 3, "R2 table short");

    load(2, 32'h0010_0003, 32'h0040_0002);
    run(18'h00000, 18'h08000, '1, 0, "R1 R6 region change");
    run(18'h0C000, 18'h08000, '1, 0, "R7 chip wrap");
    run(18'h04800, 18'h04000, '1, 1, "R4 start misaligned");
    run(18'h00000, 18'h05000, '1, 1, "R5 end misaligned");
    run(18'h1C000, 18'h08000, '1, 1, "R3 end beyond");
    run(18'h20001, 18'h00000, '1, 1, "R3 start beyond");
    run(18'h1C000, 18'h04000, '1, 0, "R5 end at device size");
    run(18'h00000, 18'h04000, 18'h02000, 2, "R9 abort midway");
    run(18'h00000, 18'h02000, 18'h01000, 2, "R9 fail on last");
    run(18'h01000, 18'h00000, '1, 0, "R10 zero length");
    run(18'h13000, 18'h01000, '1, 0, "R8 single sector");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule